// File: doc/BRIEF.md
# Delay Slot Decoder and Phase Comparator

This block measures the delay of a received modulation signal against a locally generated time reference. An external counter splits every modulation period into 80 equal segments and presents the current segment number, together with a strobe that is high for one clock while the count is settled. A four-position coarse select and a twenty-position fine select name one segment. The block decodes that choice in two levels: first the group of twenty, then the position inside the group. The strobe qualifies the result, which gives a single-clock time pulse.

The time pulse sets a flag. The rising edge of the received, demodulated signal clears it, after a two-flop synchroniser. The decoded segment is placed twenty segments (a quarter period) ahead of the selected one. As a result, the flag's high time always includes a fixed 25% offset plus the measured delay, and the duty never sits near 0% or 100% where small jitter would wrap it.

The block reports the flag level. It also reports a digital duty measurement: the number of clocks the flag was high over the last period, latched at each segment-0 strobe.

Top module: `delay_slot_cmp`

## Requirements
- R1: While `rst_n` is low and after its release, `q_out` is 0 and `duty_cnt` is 0 until the first set pulse and the first period mark respectively.
- R2: The selected slot index is `coarse_sel*20 + fine_sel`. The decoded segment is `(index + 60) mod 80`, which is twenty segments before the selected slot.
- R3: A set pulse occurs only in a clock where `strobe` is 1 and `seg_cnt` equals the decoded segment. With `strobe` at 0, `q_out` is never set. Counter values of 80 and above never decode.
- R4: `q_out` is 1 in the clock after a set pulse. A set pulse and a receive edge in the same clock leave `q_out` at 1. With neither present, `q_out` holds.
- R5: `rx_sig` passes through two flops. A 0-to-1 change sampled at clock edge k clears `q_out` at edge k+2. A steady high level or a falling edge has no effect.
- R6: Take a received edge that arrives d segments after the selected slot. For d from 0 to 20 (coarse range), `q_out` is high for about (20+d)/80 of the period, between 25% and 50%. For d of 0 or 1 (fine range), it stays within about 25% to 26.5%.
- R7: A period mark is a clock with `strobe` 1 and `seg_cnt` 0. In the clock after a mark, `duty_cnt` shows how many clocks `q_out` was 1, counted from the previous mark clock up to the clock before this mark. `duty_cnt` does not change in any other clock.
- R8: A `fine_sel` value above 19 is treated as 19.
- R9: If the high count of one period exceeds the range of `duty_cnt`, the reported value is all ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_cnt | input | 7 | Current segment number of the divide-by-80 counter |
| coarse_sel | input | 2 | Coarse slot select, positions 0 to 3 |
| fine_sel | input | 5 | Fine slot select, positions 0 to 19 |
| strobe | input | 1 | One-clock qualifier while the segment count is settled |
| rx_sig | input | 1 | Received demodulated modulation signal, asynchronous |
| q_out | output | 1 | Set/reset flag level |
| duty_cnt | output | DUTY_W | Clocks of `q_out` high in the last complete period |

## Verification
Two cases are hardest to reach from the ports. The first is the period in which the high count overflows the duty counter. The second is a run with the strobe withheld, where no set and no mark may happen while the counter still sweeps every segment. The bench instantiates the block with an 8-bit duty counter and places the received edge 59 segments after the slot, so one period holds about 315 high clocks. In a separate phase it gates the strobe off for two full periods while the received signal keeps toggling. A per-clock behavioural model runs beside the design through every coarse, fine and clamped-fine case.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Clamp a fine position into the legal range of the fine control.
  function automatic int unsigned clamp_fine(int unsigned fine, int unsigned fine_n);
    return (fine >= fine_n) ? (fine_n - 1) : fine;
  endfunction

  // Segment that must be decoded so that the set pulse leads the
  // selected slot by the offset (wraps around the period).
  function automatic int unsigned lead_segment(int unsigned coarse, int unsigned fine,
                                               int unsigned fine_n, int unsigned segs,
                                               int unsigned offset);
    int unsigned idx;
    idx = coarse * fine_n + clamp_fine(fine, fine_n);
    return (idx % segs + segs - (offset % segs)) % segs;
  endfunction

endpackage

// File: rtl/dsc_slot_decoder.sv
module dsc_slot_decoder #(
  parameter int unsigned SEGS     = 80,
  parameter int unsigned COARSE_N = 4,
  parameter int unsigned FINE_N   = 20,
  parameter int unsigned OFFSET   = 20,
  parameter int unsigned SEG_W    = $clog2(SEGS),
  parameter int unsigned CW       = $clog2(COARSE_N),
  parameter int unsigned FW       = $clog2(FINE_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg_cnt,
  input  logic [CW-1:0]    coarse_sel,
  input  logic [FW-1:0]    fine_sel,
  input  logic             strobe,
  output logic             slot_pulse
);
  localparam int unsigned ROWS = (SEGS + FINE_N - 1) / FINE_N;

  int unsigned seg_i, tgt, tgt_row, tgt_col, seg_row, seg_col;
  logic        seg_ok;
  logic [ROWS-1:0]   row_hit;
  logic [FINE_N-1:0] col_hit;
  logic        any_row, any_col;

  assign seg_i   = 32'(seg_cnt);
  assign seg_ok  = seg_i < SEGS;
  assign tgt     = dsc_pkg::lead_segment(32'(coarse_sel), 32'(fine_sel), FINE_N, SEGS, OFFSET);
  assign tgt_row = tgt / FINE_N;
  assign tgt_col = tgt % FINE_N;
  assign seg_row = seg_i / FINE_N;
  assign seg_col = seg_i % FINE_N;

  // Level one: group of FINE_N segments
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_hit[g] = (seg_row == 32'(g)) && (tgt_row == 32'(g));
  end
  // Level two: position inside the group
  for (genvar f = 0; f < FINE_N; f++) begin : g_col
    assign col_hit[f] = (seg_col == 32'(f)) && (tgt_col == 32'(f));
  end

  assign any_row    = |row_hit;
  assign any_col    = |col_hit;
  // Final strobe qualification removes counter-transition ambiguity
  assign slot_pulse = seg_ok && any_row && any_col && strobe;

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pulse |-> (strobe && seg_ok)); // R3
  AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_hit)); // R2
endmodule

// File: rtl/dsc_rx_edge.sv
module dsc_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rx_rise = s2 && !s3;

  AST_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |-> $past(rx_in, 2)); // R5
endmodule

// File: rtl/dsc_duty_meter.sv
module dsc_duty_meter #(
  parameter int unsigned DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark,
  input  logic              q_in,
  output logic [DUTY_W-1:0] duty_cnt
);
  localparam logic [DUTY_W-1:0] TOP = '1;

  logic [DUTY_W-1:0] acc;
  logic              at_top;

  assign at_top = (acc == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      duty_cnt <= '0;
    end else if (mark) begin
      duty_cnt <= acc;
      acc      <= DUTY_W'(q_in);
    end else if (q_in && !at_top) begin
      acc <= acc + 1'b1;
    end
  end

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mark |=> $stable(duty_cnt)); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !mark) |=> at_top); // R9
endmodule

// File: rtl/delay_slot_cmp.sv
module delay_slot_cmp #(
  parameter int unsigned SEGS     = 80,
  parameter int unsigned COARSE_N = 4,
  parameter int unsigned FINE_N   = 20,
  parameter int unsigned OFFSET   = 20,
  parameter int unsigned DUTY_W   = 16,
  parameter int unsigned SEG_W    = $clog2(SEGS),
  parameter int unsigned CW       = $clog2(COARSE_N),
  parameter int unsigned FW       = $clog2(FINE_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  seg_cnt,
  input  logic [CW-1:0]     coarse_sel,
  input  logic [FW-1:0]     fine_sel,
  input  logic              strobe,
  input  logic              rx_sig,
  output logic              q_out,
  output logic [DUTY_W-1:0] duty_cnt
);
  logic slot_pulse;   // decoded, strobed time pulse
  logic rx_rise;      // synchronised receive edge
  logic period_mark;  // segment-0 strobe

  dsc_slot_decoder #(
    .SEGS(SEGS), .COARSE_N(COARSE_N), .FINE_N(FINE_N), .OFFSET(OFFSET),
    .SEG_W(SEG_W), .CW(CW), .FW(FW)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .seg_cnt(seg_cnt), .coarse_sel(coarse_sel),
    .fine_sel(fine_sel), .strobe(strobe), .slot_pulse(slot_pulse)
  );

  dsc_rx_edge u_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_sig), .rx_rise(rx_rise)
  );

  assign period_mark = strobe && (seg_cnt == '0);

  // Set has priority over reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_out <= 1'b0;
    else if (slot_pulse) q_out <= 1'b1;
    else if (rx_rise)    q_out <= 1'b0;
  end

  dsc_duty_meter #(.DUTY_W(DUTY_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .mark(period_mark), .q_in(q_out), .duty_cnt(duty_cnt)
  );

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pulse |=> q_out); // R4
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rise && !slot_pulse) |=> !q_out); // R5
  AST_Q_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_pulse && !rx_rise) |=> $stable(q_out)); // R4
endmodule

// File: tb/delay_slot_cmp_bench.sv
module delay_slot_cmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_CLKS   = 4;
  localparam int PER_CLKS   = 80 * SEG_CLKS;
  localparam int DW         = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [6:0]    seg_cnt = '0;
  logic [1:0]    coarse_sel = '0;
  logic [4:0]    fine_sel = '0;
  logic          strobe = 0;
  logic          rx_sig = 0;
  logic          q_out;
  logic [DW-1:0] duty_cnt;

  int checks = 0, fails = 0;
  int cyc = 0, rx_pos = 0;
  bit strobe_en = 1, done = 0;

  // behavioural model state
  bit rx_hist[$];
  bit m_q;
  int m_acc, m_duty;

  delay_slot_cmp #(.DUTY_W(DW)) u_delay_slot_cmp (
    .clk(clk), .rst_n(rst_n), .seg_cnt(seg_cnt), .coarse_sel(coarse_sel),
    .fine_sel(fine_sel), .strobe(strobe), .rx_sig(rx_sig),
    .q_out(q_out), .duty_cnt(duty_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lead_of(int c, int f);
    int ff;
    ff = (f > 19) ? 19 : f;
    return (c * 20 + ff + 60) % 80;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rx_hist = '{0, 0, 0, 0};
      m_q = 0; m_acc = 0; m_duty = 0;
    end else begin
      bit hit, edge_seen, q_old;
      rx_hist.push_front(rx_sig);
      void'(rx_hist.pop_back());
      edge_seen = rx_hist[2] && !rx_hist[3];
      hit = strobe && (int'(seg_cnt) == lead_of(int'(coarse_sel), int'(fine_sel)));
      q_old = m_q;
      if (hit) m_q = 1;
      else if (edge_seen) m_q = 0;
      if (strobe && seg_cnt == 0) begin
        m_duty = m_acc;
        m_acc = q_old;
      end else if (q_old && m_acc < (1 << DW) - 1) m_acc++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      if (rst_n) begin
        check(q_out == m_q, "R4 R5 q_out vs model", q_out, m_q);
        check(int'(duty_cnt) == m_duty, "R7 duty_cnt vs model", duty_cnt, m_duty);
      end
      cyc++;
      seg_cnt = 7'((cyc / SEG_CLKS) % 80);
      strobe  = strobe_en && (cyc % SEG_CLKS == 2);
      rx_sig  = ((cyc + PER_CLKS - rx_pos) % PER_CLKS) < PER_CLKS / 2;
    end
  endtask

  // Select a slot and place the receive edge d segments after it.
  task automatic scenario(int c, int f, int d);
    int ff;
    ff = (f > 19) ? 19 : f;
    coarse_sel = 2'(c);
    fine_sel   = 5'(f);
    rx_pos     = ((c * 20 + ff + d) % 80) * SEG_CLKS;
    run(3 * PER_CLKS);
  endtask

  function automatic int approx_high(int d);
    int h;
    h = (20 + d) * SEG_CLKS - 1;
    return (h > (1 << DW) - 1) ? (1 << DW) - 1 : h;
  endfunction

  initial begin
    int held, tol, fine19;
    tol = SEG_CLKS;
    repeat (3) @(negedge clk);
    check(q_out == 0, "R1 q_out in reset", q_out, 0);
    check(duty_cnt == 0, "R1 duty_cnt in reset", duty_cnt, 0);
    rst_n = 1;
    run(5);
    check(q_out == 0, "R1 q_out after release", q_out, 0);
    check(duty_cnt == 0, "R1 duty_cnt after release", duty_cnt, 0);

    // R2 R6: coarse range, delay 0..20 segments
    scenario(0, 0, 0);
    check((int'(duty_cnt) - approx_high(0)) <= tol && (approx_high(0) - int'(duty_cnt)) <= tol,
          "R6 R2 coarse0 d0 25pct", duty_cnt, approx_high(0));
    scenario(1, 5, 10);
    check((int'(duty_cnt) - approx_high(10)) <= tol && (approx_high(10) - int'(duty_cnt)) <= tol,
          "R6 R2 coarse1 d10", duty_cnt, approx_high(10));
    scenario(3, 19, 20);
    check((int'(duty_cnt) - approx_high(20)) <= tol && (approx_high(20) - int'(duty_cnt)) <= tol,
          "R6 R2 coarse3 d20 50pct", duty_cnt, approx_high(20));
    scenario(2, 0, 5);
    check((int'(duty_cnt) - approx_high(5)) <= tol && (approx_high(5) - int'(duty_cnt)) <= tol,
          "R6 R2 coarse2 d5 wrap", duty_cnt, approx_high(5));
    // fine range: within one segment of the offset
    scenario(0, 3, 1);
    check(int'(duty_cnt) >= 20 * SEG_CLKS - tol && int'(duty_cnt) <= 85,
          "R6 fine d1 near 25pct", duty_cnt, approx_high(1));

    // R8: fine above 19 acts as 19
    scenario(2, 19, 7);
    fine19 = duty_cnt;
    scenario(2, 27, 7);
    check(int'(duty_cnt) == fine19, "R8 fine 27 equals fine 19", duty_cnt, fine19);

    // R9: saturation of an 8-bit duty counter
    scenario(1, 10, 59);
    check(int'(duty_cnt) == (1 << DW) - 1, "R9 duty saturates", duty_cnt, (1 << DW) - 1);

    // R3 R7: strobe withheld, no set and no duty update
    scenario(1, 2, 3);
    strobe_en = 0;
    run(PER_CLKS);
    held = duty_cnt;
    run(2 * PER_CLKS);
    check(q_out == 0, "R3 no set without strobe", q_out, 0);
    check(int'(duty_cnt) == held, "R7 duty held without mark", duty_cnt, held);
    strobe_en = 1;
    run(2 * PER_CLKS);
    check(q_out == m_q, "R3 recovery after strobe returns", q_out, m_q);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule